// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block gathers 64 level-sensitive interrupt lines and presents one interrupt request to a processor. Each line has an enable bit and a 4-bit priority. Software reaches them through a small 32-bit register bus. A line takes part in arbitration only while its input is high, its enable bit is set, and its priority lies above the programmable priority mask. Among such lines the controller picks the one with the highest priority. It reports that line's number and priority in a single status word, which the interrupt handler reads to find out whom to serve.

Enables change one line at a time: software writes a line number to a set port or to a clear port. Priorities are packed eight to a word. A typical handler reads the status word, raises the mask to the level it serves, runs the service routine, restores the mask and reads the status word again. It stops when the word comes back negative.

The bus response path is a two-state machine. In state `BUS_IDLE` no read is in flight and the read data port drives zero. The transition *read-accept* moves it to `BUS_RESP` whenever the read strobe is high. In `BUS_RESP` the port presents the word captured at the strobe edge. The transition *read-chain* keeps it in `BUS_RESP` when a new strobe arrives in that cycle. The transition *read-done* returns it to `BUS_IDLE` when no strobe is present.

Top module: `icu_top`

## Requirements
- R1: Writing to byte offset 0x04 sets the enable bit of the source whose number is in wdata[5:0]. Bits 31:6 are ignored and no other enable bit changes. Reading offset 0x04 returns zero.
- R2: Writing to byte offset 0x08 clears the enable bit of the source numbered in wdata[5:0], and only that bit. Reading 0x08 returns zero. Enable bits change only through 0x04 and 0x08. Offset 0x0C reads enables 31:0 and offset 0x10 reads enables 63:32.
- R3: The priority of source s lives in the read/write word at byte offset 0x3C − 4·(s div 8), in bits [4·(s mod 8)+3 : 4·(s mod 8)]. Sources 0–7 are at 0x3C and sources 56–63 are at 0x20.
- R4: A read of offset 0x14 returns the winning source number in bits 31:16 and its priority in bits 15:0, both zero-extended. When no source qualifies it returns 0xFFFF_FFFF.
- R5: Among qualifying sources the one with the highest priority value wins. On a priority tie the larger source number wins.
- R6: The mask register at offset 0x00 holds 5 bits. While bit 4 is set nothing is masked. While bit 4 is clear, every source whose priority is less than or equal to bits 3:0 is excluded. Reads return the 5 bits zero-extended.
- R7: A source qualifies only in a cycle in which its input is high and its enable bit is set. Dropping the input withdraws it in that same cycle.
- R8: irq_o is high exactly one clock after a cycle in which some source qualified.
- R9: Reset clears every enable bit and every priority field, sets the mask to 0x1F, and holds irq_o low.
- R10: Read data appears on the cycle after the read strobe and is zero in any cycle not preceded by a strobe. Reads of offsets 0x18, 0x1C and 0x40 and above return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Level-sensitive interrupt inputs, one per source |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the controller with its default parameters: 64 sources, 4-bit priorities and an 8-bit byte address. With those values all eight priority words can be reached, from 0x3C down to 0x20. Source number 63 is reachable, so the top of the 6-bit number field in the status word is exercised, and both enable readback words are full. The fixed cases cover ties across priority words, a mask equal to the winning level, and inputs that drop while still enabled. A random phase mixes enable, priority and mask writes under changing inputs, and a behavioural model compares irq_o on every clock.

// File: rtl/icu_pkg.sv
package icu_pkg;

    // Register word indices (byte offset / 4)
    localparam int WORD_MASK     = 0;
    localparam int WORD_EN_SET   = 1;
    localparam int WORD_EN_CLR   = 2;
    localparam int WORD_EN_LO    = 3;
    localparam int WORD_EN_HI    = 4;
    localparam int WORD_VECTOR   = 5;
    localparam int WORD_PRIO_LOW = 8;

    localparam int BUS_W = 32;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int PW   = 4,
    parameter int AW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [AW-1:0]        word,
    input  logic [BUS_W-1:0]     wdata,
    output logic [NSRC-1:0]      en_o,
    output logic [NSRC*PW-1:0]   prio_o,
    output logic [PW:0]          mask_o
);
    localparam int IDW  = $clog2(NSRC);
    localparam int PER  = BUS_W / PW;
    localparam int NGRP = NSRC / PER;

    logic [NSRC-1:0]    en_q;
    logic [NSRC*PW-1:0] prio_q;
    logic [PW:0]        mask_q;

    logic hit_set, hit_clr, hit_mask;
    assign hit_set  = wr && (word == AW'(WORD_EN_SET));
    assign hit_clr  = wr && (word == AW'(WORD_EN_CLR));
    assign hit_mask = wr && (word == AW'(WORD_MASK));

    // enable bits, one per write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (hit_set) begin
            en_q[wdata[IDW-1:0]] <= 1'b1;
        end else if (hit_clr) begin
            en_q[wdata[IDW-1:0]] <= 1'b0;
        end
    end

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (hit_mask) begin
            mask_q <= wdata[PW:0];
        end
    end

    // priority words, descending address with rising source index
    for (genvar g = 0; g < NGRP; g++) begin : g_prio
        localparam int GWORD = WORD_PRIO_LOW + NGRP - 1 - g;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[g*BUS_W +: BUS_W] <= '0;
            end else if (wr && (word == AW'(GWORD))) begin
                prio_q[g*BUS_W +: BUS_W] <= wdata;
            end
        end
    end

    assign en_o   = en_q;
    assign prio_o = prio_q;
    assign mask_o = mask_q;

    // R1: a set write touches at most one bit, and it ends up set
    assert_set_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ($countones(en_q ^ $past(en_q)) <= 1) && ((en_q & ~$past(en_q)) == (en_q ^ $past(en_q))));

    // R2: a clear write touches at most one bit, and only by clearing
    assert_clr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ($countones(en_q ^ $past(en_q)) <= 1) && ((~en_q & $past(en_q)) == (en_q ^ $past(en_q))));

    // R2: enables hold without a set or clear write
    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_set || hit_clr) |=> $stable(en_q));

endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import icu_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int PW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src,
    input  logic [NSRC-1:0]      en,
    input  logic [NSRC*PW-1:0]   prio,
    input  logic [PW:0]          mask,
    output logic                 win_valid,
    output logic [$clog2(NSRC)-1:0] win_id,
    output logic [PW-1:0]        win_prio
);
    localparam int IDW   = $clog2(NSRC);
    localparam int KW    = 1 + PW + IDW;
    localparam int NODES = 2*NSRC - 1;

    // key = {qualifies, priority, index}; larger key wins
    logic [KW-1:0] node [NODES];
    logic [NSRC-1:0] qual;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            qual[i] = src[i] && en[i] &&
                      (mask[PW] || (prio[i*PW +: PW] > mask[PW-1:0]));
            node[NSRC-1+i] = qual[i] ? {1'b1, prio[i*PW +: PW], IDW'(i)} : '0;
        end
        for (int j = NSRC-2; j >= 0; j--) begin
            node[j] = (node[2*j+1] > node[2*j+2]) ? node[2*j+1] : node[2*j+2];
        end
    end

    assign win_valid = node[0][KW-1];
    assign win_prio  = node[0][KW-2 -: PW];
    assign win_id    = node[0][IDW-1:0];

    // R7: the reported source is high and enabled
    assert_win_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (src[win_id] && en[win_id]));

    // R6: the reported level lies above an active mask
    assert_win_above_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !mask[PW]) |-> (win_prio > mask[PW-1:0]));

    // R3: the reported level is the source's programmed field
    assert_win_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_prio == prio[win_id*PW +: PW]));

endmodule

// File: rtl/icu_bus.sv
module icu_bus
    import icu_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int PW   = 4,
    parameter int AW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd,
    input  logic [AW-1:0]        word,
    input  logic [NSRC-1:0]      en,
    input  logic [NSRC*PW-1:0]   prio,
    input  logic [PW:0]          mask,
    input  logic                 win_valid,
    input  logic [$clog2(NSRC)-1:0] win_id,
    input  logic [PW-1:0]        win_prio,
    output logic [BUS_W-1:0]     rdata
);
    localparam int NGRP = NSRC / (BUS_W / PW);
    localparam int HALF = BUS_W / 2;

    bus_state_e       state_q, state_d;
    logic [BUS_W-1:0] rd_mux, rdata_q;
    logic [2*BUS_W-1:0] en_pad;
    logic             word_known;

    assign en_pad = (2*BUS_W)'(en);

    always_comb begin
        rd_mux = '0;
        if (word == AW'(WORD_MASK))        rd_mux = BUS_W'(mask);
        else if (word == AW'(WORD_EN_LO))  rd_mux = en_pad[BUS_W-1:0];
        else if (word == AW'(WORD_EN_HI))  rd_mux = en_pad[2*BUS_W-1:BUS_W];
        else if (word == AW'(WORD_VECTOR))
            rd_mux = win_valid ? {HALF'(win_id), HALF'(win_prio)} : '1;
        for (int g = 0; g < NGRP; g++) begin
            if (word == AW'(WORD_PRIO_LOW + NGRP - 1 - g))
                rd_mux = prio[g*BUS_W +: BUS_W];
        end
    end

    assign word_known = (word <= AW'(WORD_VECTOR)) ||
                        ((word >= AW'(WORD_PRIO_LOW)) && (word < AW'(WORD_PRIO_LOW + NGRP)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_mux;
    end

    // transitions: read-accept, read-chain, read-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rdata = '0;
        unique case (state_q)
            BUS_IDLE: rdata = '0;
            BUS_RESP: rdata = rdata_q;
            default:  rdata = '0;
        endcase
    end

    // R10: unmapped reads return zero on the following cycle
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !word_known) |=> (rdata == '0));

    // R10: no strobe, no data
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0));

endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PW     = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int AW  = ADDR_W - 2;
    localparam int IDW = $clog2(NSRC);

    logic [AW-1:0]      word;
    logic [NSRC-1:0]    en;
    logic [NSRC*PW-1:0] prio;
    logic [PW:0]        mask;
    logic               win_valid;
    logic [IDW-1:0]     win_id;
    logic [PW-1:0]      win_prio;
    logic               irq_q;

    assign word = bus_addr[ADDR_W-1:2];

    icu_regs #(.NSRC(NSRC), .PW(PW), .AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .word   (word),
        .wdata  (bus_wdata),
        .en_o   (en),
        .prio_o (prio),
        .mask_o (mask)
    );

    icu_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src_i),
        .en        (en),
        .prio      (prio),
        .mask      (mask),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    icu_bus #(.NSRC(NSRC), .PW(PW), .AW(AW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .word      (word),
        .en        (en),
        .prio      (prio),
        .mask      (mask),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio),
        .rdata     (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= win_valid;
    end

    assign irq_o = irq_q;

    // R8: request follows a qualifying cycle by one clock
    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> irq_o);

    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> !irq_o);

endmodule

// File: tb/tb_icu_top.sv
`timescale 1ns/1ps
module tb_icu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    // reference state
    bit m_en [64];
    int m_prio [64];
    int m_mask = 31;

    always #2 clk = ~clk;

    icu_top dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // winner: scan upward, take >= so the later index wins a tie
    task automatic m_eval(input logic [63:0] s, output bit v, output int id, output int p);
        v = 0; id = 0; p = 0;
        for (int i = 0; i < 64; i++) begin
            if (s[i] && m_en[i] && (m_mask >= 16 || m_prio[i] > m_mask)) begin
                if (!v || m_prio[i] >= p) begin
                    v = 1; id = i; p = m_prio[i];
                end
            end
        end
    endtask

    function automatic logic [31:0] m_read(input int w, input bit v, input int id, input int p);
        logic [31:0] r;
        r = '0;
        if (w == 0) r = 32'(m_mask);
        else if (w == 3) for (int i = 0; i < 32; i++) r[i] = m_en[i];
        else if (w == 4) for (int i = 0; i < 32; i++) r[i] = m_en[32+i];
        else if (w == 5) r = v ? {16'(id), 16'(p)} : 32'hFFFF_FFFF;
        else if (w >= 8 && w <= 15)
            for (int f = 0; f < 8; f++) r[4*f +: 4] = 4'(m_prio[(15-w)*8 + f]);
        return r;
    endfunction

    task automatic m_write(input int w, input logic [31:0] d);
        if (w == 0) m_mask = int'(d[4:0]);
        else if (w == 1) m_en[d[5:0]] = 1;
        else if (w == 2) m_en[d[5:0]] = 0;
        else if (w >= 8 && w <= 15)
            for (int f = 0; f < 8; f++) m_prio[(15-w)*8 + f] = int'(d[4*f +: 4]);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit w, input bit r, input logic [7:0] a,
                        input logic [31:0] d, input string req);
        bit v; int id, p; bit live;
        logic [31:0] er;
        live = rst_n;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        m_eval(src, v, id, p);
        er = m_read(int'(a[7:2]), v, id, p);
        @(posedge clk);
        if (w && live) m_write(int'(a[7:2]), d);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        chk(live ? "R8 irq" : "R9 irq in reset", {31'd0, irq_o}, {31'd0, live & v});
        if (r) chk(req, bus_rdata, er);
        else   chk("R10 idle data", bus_rdata, 32'd0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        step(1, 0, a, d, req);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(0, 1, a, 32'd0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_en[i] = 0; m_prio[i] = 0; end
        @(negedge clk);
        src = '1;
        step(0, 0, 8'h00, 0, "R9");
        step(0, 0, 8'h00, 0, "R9");
        rst_n = 1'b1;
        src = '0;
        // R9 reset values
        rd(8'h00, "R9 mask reset");
        rd(8'h0C, "R9 enables lo reset");
        rd(8'h10, "R9 enables hi reset");
        rd(8'h3C, "R9 prio reset");
        rd(8'h20, "R9 prio reset");
        rd(8'h14, "R4 vector empty");
        // R7 nothing enabled, all inputs high
        src = '1;
        rd(8'h14, "R7 disabled sources");
        // R1 enable source 5 with junk upper bits
        wr(8'h04, 32'hABCD_0005, "R1");
        rd(8'h0C, "R1 set one bit");
        rd(8'h04, "R1 set port reads zero");
        rd(8'h14, "R4 vector source 5");
        // R3 priority of source 5 = 3; source 40 = 3 (word 0x28)
        wr(8'h3C, 32'h0030_0000, "R3");
        wr(8'h28, 32'h0000_0003, "R3");
        rd(8'h3C, "R3 prio readback");
        wr(8'h04, 32'd40, "R1");
        rd(8'h10, "R1 set high half");
        rd(8'h14, "R5 tie larger index");
        // source 63 prio 7 at 0x20 bits 31:28
        wr(8'h20, 32'h7000_0000, "R3");
        wr(8'h04, 32'd63, "R1");
        rd(8'h14, "R5 highest priority");
        // R6 masking
        wr(8'h00, 32'h0000_0007, "R6");
        rd(8'h14, "R6 mask equal blocks");
        rd(8'h00, "R6 mask readback");
        wr(8'h00, 32'h0000_0002, "R6");
        rd(8'h14, "R6 mask below");
        // R7 level input drops
        src[63] = 1'b0; src[40] = 1'b0;
        rd(8'h14, "R7 input dropped");
        src[40] = 1'b1;
        rd(8'h14, "R7 input returns");
        // R2 clear
        wr(8'h08, 32'd40, "R2");
        rd(8'h10, "R2 clear one bit");
        rd(8'h0C, "R2 other half untouched");
        rd(8'h08, "R2 clear port reads zero");
        wr(8'h00, 32'h0000_001F, "R6");
        // R10 unmapped offsets
        wr(8'h18, 32'hFFFF_FFFF, "R10");
        wr(8'h1C, 32'hFFFF_FFFF, "R10");
        wr(8'h40, 32'hFFFF_FFFF, "R10");
        rd(8'h18, "R10 unmapped read");
        rd(8'h44, "R10 unmapped read");
        rd(8'h0C, "R10 write ignored");
        rd(8'h10, "R10 write ignored");
        rd(8'h00, "R10 write ignored");
        rd(8'h14, "R10 vector unchanged");
        // back-to-back reads (read-chain)
        rd(8'h3C, "R10 chained read");
        rd(8'h20, "R10 chained read");
        // random mixing
        for (int n = 0; n < 400; n++) begin
            int op;
            src = {$urandom, $urandom};
            op = int'($urandom_range(0, 5));
            case (op)
                0, 1: wr(8'h04, $urandom, "R1 random");
                2:    wr(8'h08, $urandom, "R2 random");
                3:    wr(8'(32 + 4*$urandom_range(0, 7)), $urandom, "R3 random");
                4:    wr(8'h00, 32'($urandom_range(0, 31)), "R6 random");
                default: rd(8'(4*$urandom_range(0, 17)), "R10 random read");
            endcase
            rd(8'h14, "R5 random vector");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule